// File: doc/BRIEF.md
# Watchdog Timer with Timed Unlock

This block is a watchdog timer. Unless software strobes a kick input often enough, it raises a one-cycle system-reset pulse. A control register holds an enable bit and a three-bit period select. Changes that could weaken protection go through a two-step write sequence that must finish inside a short window. Those changes are switching the timer off and altering its period.

The first step is a single write with both the change-enable bit and the enable bit at one. That write opens a window of four clock cycles. During the window, one write with change-enable at zero commits the new enable and period values. The same write also closes the window and restarts the timeout count.

A static level input picks how strict the protection is. At the relaxed level the timer starts switched off, and software may switch it on with any plain write. At the locked level the timer always runs, and only the period can be changed through the sequence.

Top module: `wdt_guard`

## Requirements
- R1: At the relaxed level (`safe_lvl2`=0), after reset `rd_ena`=0, `rd_unlock`=0, `rd_psel`=0 and `sys_rst`=0.
- R2: At the relaxed level, any write with `wr_ena`=1 sets the enable, including the opening write of a sequence. `wr_psel` is ignored by any write that is not a committed second step.
- R3: At the relaxed level, a write with `wr_ena`=0 leaves `rd_ena` at one when no window is open.
- R4: A write with `wr_unlock`=1 and `wr_ena`=1 opens the window, and `rd_unlock` reads one while it is open. A write with `wr_unlock`=1 and `wr_ena`=0 opens nothing.
- R5: If the opening write is at clock edge k, a write with `wr_unlock`=0 at edges k+1 through k+4 is committed. At edge k+5 and later it is ignored, and `rd_unlock` reads zero from edge k+4 on.
- R6: A committed write loads `wr_psel` into the period select and, at the relaxed level, `wr_ena` into the enable. It then closes the window, so a further protected write is ignored.
- R7: At the relaxed level, a committed write of all zeros switches the timer off. While the timer is off, `sys_rst` stays low.
- R8: The timeout is 2^(BASE_EXP+`rd_psel`) ticks. If the count starts from zero at edge e, `sys_rst` is high for exactly one cycle after edge e+L (with one tick per cycle), and the count then restarts.
- R9: A `kick` pulse clears the count, so the next `sys_rst` comes a full timeout after the kick edge.
- R10: A committed write clears the count, so the new period runs in full from the commit edge.
- R11: At the locked level (`safe_lvl2`=1), `rd_ena` always reads one and the timer runs from reset. A written enable value has no effect, and `rd_psel` changes only through the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| safe_lvl2 | input | 1 | Protection level: 0 relaxed, 1 locked (static) |
| wr_en | input | 1 | Control register write strobe |
| wr_ena | input | 1 | Written enable bit |
| wr_unlock | input | 1 | Written change-enable bit |
| wr_psel | input | PSEL_W | Written period select |
| kick | input | 1 | Watchdog restart strobe |
| rd_ena | output | 1 | Read-back of effective enable |
| rd_unlock | output | 1 | Read-back of change-enable (window open) |
| rd_psel | output | PSEL_W | Read-back of period select |
| sys_rst | output | 1 | One-cycle system-reset pulse on timeout |

## Verification
The bench measures the distance from the start of a count to `sys_rst` for three period selects. A wrong shift base or an off-by-one in the compare shows up as a wrong cycle count. The sequence is tried with the second write placed on the last cycle of the window and on the first cycle after it, which separates a four-cycle window from a three- or five-cycle one. Opening attempts with the enable bit clear, plain writes that try to disable the timer or change its period, and repeated protected writes after a commit check that each rule blocks what it should. The same writes are then repeated at the locked level, where the enable value must have no effect.

// File: rtl/wdt_guard_pkg.sv
// Package wdt_guard_pkg
// Shared constants and types for the watchdog with timed unlock.
// Assumes a three-bit period select and a four-cycle unlock window.
package wdt_guard_pkg;

    localparam int WDT_PSEL_W  = 3;
    localparam int WDT_WIN_CYC = 4;

    // Protection level selected by the static level input.
    typedef enum logic {
        LVL_RELAXED = 1'b0,
        LVL_LOCKED  = 1'b1
    } wdt_lvl_e;

    // One control register write as seen by the unlock logic.
    typedef struct packed {
        logic                  ena;
        logic                  unlock;
        logic [WDT_PSEL_W-1:0] psel;
    } wdt_wr_t;

endpackage

// File: rtl/wdt_unlock_fsm.sv
// Module wdt_unlock_fsm
// Holds the enable bit and the period select. It opens a timed window on a
// write with change-enable and enable both set, and commits one second write
// made inside that window. Pulses commit_o when a commit happens.
// Assumes the level input is static while out of reset.
module wdt_unlock_fsm
    import wdt_guard_pkg::*;
#(
    parameter int WIN_CYC = WDT_WIN_CYC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wdt_lvl_e              lvl_i,
    input  logic                  wr_en_i,
    input  wdt_wr_t               wr_i,
    output logic                  ena_o,
    output logic [WDT_PSEL_W-1:0] psel_o,
    output logic                  win_open_o,
    output logic                  commit_o
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYC);

    logic                  ena_q;
    logic [WDT_PSEL_W-1:0] psel_q;
    logic [WIN_W-1:0]      win_q;
    logic                  open_req;
    logic                  win_open;
    logic                  commit;

    // Classify the current write: opening step, committed step, or plain.
    always_comb begin
        win_open = (win_q != '0);
        open_req = wr_en_i && wr_i.unlock && wr_i.ena;
        commit   = wr_en_i && !wr_i.unlock && win_open;
    end

    // Window countdown: reload on opening write, close on commit, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (open_req) begin
            win_q <= WIN_LOAD;
        end else if (commit) begin
            win_q <= '0;
        end else if (win_open) begin
            win_q <= win_q - 1'b1;
        end
    end

    // Enable bit: set freely at the relaxed level, cleared only by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= 1'b0;
        end else if (lvl_i == LVL_RELAXED) begin
            if (commit) begin
                ena_q <= wr_i.ena;
            end else if (wr_en_i && wr_i.ena) begin
                ena_q <= 1'b1;
            end
        end
    end

    // Period select: loaded only by a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel_q <= '0;
        end else if (commit) begin
            psel_q <= wr_i.psel;
        end
    end

    // Effective outputs: the locked level forces the enable on.
    always_comb begin
        ena_o      = (lvl_i == LVL_LOCKED) ? 1'b1 : ena_q;
        psel_o     = psel_q;
        win_open_o = win_open;
        commit_o   = commit;
    end

endmodule

// File: rtl/wdt_tick_gen.sv
// Module wdt_tick_gen
// Divides the clock into a one-cycle tick every DIV cycles that feeds the
// timeout counter. With DIV of one, the tick is always high.
// Assumes DIV is at least one.
module wdt_tick_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_nodiv
            // Every cycle is a tick.
            always_comb tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] div_q;

            // Free-running divider that wraps at DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            // Tick on the wrap cycle.
            always_comb tick_o = (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/wdt_timeout_ctr.sv
// Module wdt_timeout_ctr
// Counts ticks while running. When the count reaches 2^(BASE_EXP+psel)
// ticks, it drives a registered one-cycle expiry pulse and restarts from
// zero. A clear or a stop forces the count to zero and suppresses the pulse.
// Assumes BASE_EXP is at least one, so a pulse never falls on two
// consecutive cycles.
module wdt_timeout_ctr #(
    parameter int BASE_EXP = 14,
    parameter int PSEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic              expire_o
);

    localparam int CNT_W = BASE_EXP + (1 << PSEL_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic             exp_q;
    logic             at_lim;

    // Last count value before expiry for the selected period.
    always_comb begin
        lim_m1 = (CNT_W'(1) << (BASE_EXP + int'(psel_i))) - CNT_W'(1);
        at_lim = (cnt_q == lim_m1);
    end

    // Count ticks, wrap at the limit, and register the expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (!run_i || clr_i) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (tick_i) begin
            if (at_lim) begin
                cnt_q <= '0;
                exp_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                exp_q <= 1'b0;
            end
        end else begin
            exp_q <= 1'b0;
        end
    end

    // Expose the registered pulse.
    always_comb expire_o = exp_q;

endmodule

// File: rtl/wdt_guard.sv
// Module wdt_guard (top)
// Watchdog timer whose control register is guarded by a timed two-step
// change sequence. Ties together the unlock logic, the tick divider and the
// timeout counter. A kick or a committed change restarts the count.
// Assumes safe_lvl2 is static and reset is synchronous active-low.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int TICK_DIV = 1,
    parameter int WIN_CYC  = WDT_WIN_CYC,
    parameter int PSEL_W   = WDT_PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              safe_lvl2,
    input  logic              wr_en,
    input  logic              wr_ena,
    input  logic              wr_unlock,
    input  logic [PSEL_W-1:0] wr_psel,
    input  logic              kick,
    output logic              rd_ena,
    output logic              rd_unlock,
    output logic [PSEL_W-1:0] rd_psel,
    output logic              sys_rst
);

    wdt_lvl_e              lvl;
    wdt_wr_t               wr_req;
    logic                  ena_eff;
    logic [WDT_PSEL_W-1:0] psel_q;
    logic                  win_open;
    logic                  commit;
    logic                  tick;
    logic                  ctr_clr;

    // Map the raw ports onto package types.
    always_comb begin
        lvl           = safe_lvl2 ? LVL_LOCKED : LVL_RELAXED;
        wr_req.ena    = wr_ena;
        wr_req.unlock = wr_unlock;
        wr_req.psel   = WDT_PSEL_W'(wr_psel);
        ctr_clr       = kick || commit;
    end

    wdt_unlock_fsm #(
        .WIN_CYC (WIN_CYC)
    ) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl),
        .wr_en_i    (wr_en),
        .wr_i       (wr_req),
        .ena_o      (ena_eff),
        .psel_o     (psel_q),
        .win_open_o (win_open),
        .commit_o   (commit)
    );

    wdt_tick_gen #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    wdt_timeout_ctr #(
        .BASE_EXP (BASE_EXP),
        .PSEL_W   (WDT_PSEL_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .run_i    (ena_eff),
        .clr_i    (ctr_clr),
        .psel_i   (psel_q),
        .expire_o (sys_rst)
    );

    // Read-back port.
    always_comb begin
        rd_ena    = ena_eff;
        rd_unlock = win_open;
        rd_psel   = PSEL_W'(psel_q);
    end

endmodule

// File: rtl/wdt_guard_chk.sv
// Module wdt_guard_chk
// Port-level temporal checks for wdt_guard, attached with bind.
// Assumes BASE_EXP of at least one, so expiry pulses are never adjacent.
module wdt_guard_chk #(
    parameter int PSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              safe_lvl2,
    input logic              wr_en,
    input logic              wr_ena,
    input logic              wr_unlock,
    input logic              kick,
    input logic              rd_ena,
    input logic              rd_unlock,
    input logic [PSEL_W-1:0] rd_psel,
    input logic              sys_rst
);

    p_opens_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_unlock && wr_ena) |=> rd_unlock);

    p_no_disable_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!safe_lvl2 && rd_ena && !rd_unlock) |=> rd_ena);

    p_psel_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_unlock |=> $stable(rd_psel));

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ena |=> !sys_rst);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    p_kick_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !sys_rst);

    p_locked_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        safe_lvl2 |-> rd_ena);

endmodule

bind wdt_guard wdt_guard_chk #(.PSEL_W(PSEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .safe_lvl2 (safe_lvl2),
    .wr_en     (wr_en),
    .wr_ena    (wr_ena),
    .wr_unlock (wr_unlock),
    .kick      (kick),
    .rd_ena    (rd_ena),
    .rd_unlock (rd_unlock),
    .rd_psel   (rd_psel),
    .sys_rst   (sys_rst)
);

// File: tb/wdt_guard_tb_top.sv
// Directed bench for wdt_guard: one task per scenario, each checking itself.
// It uses BASE_EXP=3 and one tick per cycle, so the timeout is 8<<psel cycles.
module wdt_guard_tb_top;

    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          safe_lvl2 = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_ena = 1'b0;
    logic          wr_unlock = 1'b0;
    logic [PW-1:0] wr_psel = '0;
    logic          kick = 1'b0;
    logic          rd_ena;
    logic          rd_unlock;
    logic [PW-1:0] rd_psel;
    logic          sys_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdt_guard #(
        .BASE_EXP (3),
        .TICK_DIV (1),
        .WIN_CYC  (4),
        .PSEL_W   (PW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .safe_lvl2 (safe_lvl2),
        .wr_en     (wr_en),
        .wr_ena    (wr_ena),
        .wr_unlock (wr_unlock),
        .wr_psel   (wr_psel),
        .kick      (kick),
        .rd_ena    (rd_ena),
        .rd_unlock (rd_unlock),
        .rd_psel   (rd_psel),
        .sys_rst   (sys_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic do_reset(input bit lvl);
        safe_lvl2 = lvl;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input bit e, input bit u, input int p);
        wr_en = 1'b1; wr_ena = e; wr_unlock = u; wr_psel = PW'(p);
        @(negedge clk);
        wr_en = 1'b0; wr_ena = 1'b0; wr_unlock = 1'b0; wr_psel = '0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts cycles until sys_rst is seen, then checks the pulse lasts one cycle.
    task automatic expect_pulse(input string req, input int exp);
        int n = 0;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (sys_rst) begin
                n = i;
                break;
            end
        end
        chk(req, n, exp);
        @(negedge clk);
        chk({req, " one-cycle pulse"}, int'(sys_rst), 0);
    endtask

    task automatic t_reset_relaxed();
        do_reset(1'b0);
        chk("R1 ena", int'(rd_ena), 0);
        chk("R1 unlock", int'(rd_unlock), 0);
        chk("R1 psel", int'(rd_psel), 0);
        chk("R1 sys_rst", int'(sys_rst), 0);
    endtask

    task automatic t_free_enable();
        wr(1'b1, 1'b0, 5);
        chk("R2 ena set", int'(rd_ena), 1);
        chk("R2 psel ignored", int'(rd_psel), 0);
        expect_pulse("R8 timeout psel0", 8);
    endtask

    task automatic t_no_plain_disable();
        wr(1'b0, 1'b0, 0);
        chk("R3 ena kept", int'(rd_ena), 1);
    endtask

    task automatic t_kick();
        idle(3);
        do_kick();
        expect_pulse("R9 kick restart", 8);
    endtask

    task automatic t_sequence();
        wr(1'b0, 1'b1, 0);
        chk("R4 no open without ena", int'(rd_unlock), 0);
        wr(1'b1, 1'b1, 0);
        chk("R4 window open", int'(rd_unlock), 1);
        wr(1'b1, 1'b0, 1);
        chk("R6 psel loaded", int'(rd_psel), 1);
        chk("R6 window closed", int'(rd_unlock), 0);
        expect_pulse("R10 commit restart psel1", 16);
        wr(1'b0, 1'b0, 3);
        chk("R6 after commit ena", int'(rd_ena), 1);
        chk("R6 after commit psel", int'(rd_psel), 1);
    endtask

    task automatic t_window_edge();
        wr(1'b1, 1'b1, 0);
        idle(3);
        chk("R5 open on 3rd idle", int'(rd_unlock), 1);
        wr(1'b1, 1'b0, 2);
        chk("R5 4th edge commits", int'(rd_psel), 2);
        wr(1'b1, 1'b1, 0);
        idle(4);
        chk("R5 expired", int'(rd_unlock), 0);
        wr(1'b1, 1'b0, 0);
        chk("R5 5th edge ignored", int'(rd_psel), 2);
    endtask

    task automatic t_turn_off();
        int seen = 0;
        wr(1'b1, 1'b1, 0);
        wr(1'b0, 1'b0, 0);
        chk("R7 ena off", int'(rd_ena), 0);
        chk("R7 psel zero", int'(rd_psel), 0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (sys_rst) seen++;
        end
        chk("R7 no pulse when off", seen, 0);
        wr(1'b1, 1'b1, 0);
        idle(4);
        chk("R2 opening write enables", int'(rd_ena), 1);
    endtask

    task automatic t_locked();
        do_reset(1'b1);
        chk("R11 ena at reset", int'(rd_ena), 1);
        do_kick();
        expect_pulse("R11 runs from reset", 8);
        wr(1'b0, 1'b0, 3);
        chk("R11 plain psel ignored", int'(rd_psel), 0);
        chk("R11 ena stays", int'(rd_ena), 1);
        wr(1'b1, 1'b1, 0);
        wr(1'b0, 1'b0, 2);
        chk("R11 psel via sequence", int'(rd_psel), 2);
        chk("R11 ena ignores zero", int'(rd_ena), 1);
        expect_pulse("R11 timeout psel2", 32);
    endtask

    initial begin
        @(negedge clk);
        t_reset_relaxed();
        t_free_enable();
        t_no_plain_disable();
        t_kick();
        t_sequence();
        t_window_edge();
        t_turn_off();
        t_locked();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: bench did not finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule